// File: doc/BRIEF.md
# Page-Mode Asynchronous DRAM Controller

This block connects a single-word synchronous request port to an asynchronous DRAM of 1,048,576 sixteen-bit words. The DRAM is organised as 1024 rows by 1024 columns, and its row and column share one 10-bit address bus. A host request carries a 20-bit word address, a read/write flag, two byte enables and write data. The controller splits the address into a row (the upper ten bits) and a column (the lower ten bits). It then drives the row strobe, two column strobes (one per byte lane), write enable, output enable and the data bus.

After an access, the row is left open. A later access to the same row skips the row phase and runs a page-mode column cycle, in which only the column strobes toggle. An access to a different row first precharges: the row strobe goes high for a set number of cycles, and then the new row opens. Every interval is a parameter counted in clock cycles. A separate close request precharges the open row and grants the bus back to the requester, so that an outside agent can run refresh or share the pins.

Top module: `page_dram_ctrl`

## Requirements
- R1: Out of reset, `ras_n`, `ucas_n`, `lcas_n`, `we_n` and `oe_n` are all high, `dq_oe` is low, `ready` is high, and `rvalid` and `wack` are low.
- R2: The row is `addr[19:10]` and is on `mem_addr` when `ras_n` falls. The column is `addr[9:0]` and is on `mem_addr` when the column strobes fall.
- R3: A word written at an address reads back unchanged at that address, including after other rows have been opened in between.
- R4: `be[1]` drives `ucas_n` and covers data bits 15:8. `be[0]` drives `lcas_n` and covers bits 7:0. A write leaves the byte of a disabled lane untouched. On a read, `rdata` shows zero in every disabled lane.
- R5: A request to the open row causes no new fall of `ras_n`. Its completion is signalled T_CAS cycles after the accepting edge.
- R6: A request while no row is open opens the row at once. Its completion is signalled T_RCD+T_CAS cycles after the accepting edge.
- R7: A request to a different row keeps `ras_n` high for T_RP cycles before reopening. Its completion is signalled T_RP+T_RCD+T_CAS cycles after the accepting edge.
- R8: `rvalid` (read) and `wack` (write) are single-cycle pulses. `rdata` holds the read word from the `rvalid` cycle until the next read completes.
- R9: `ready` drops after a request is accepted. It returns T_CP cycles after the completion pulse rises, so the column strobes stay high for at least that long between page cycles.
- R10: While `close_req` is high, `ready` is low. With a row open, `close_gnt` rises T_RP cycles after the first edge that sees `close_req`, with the row strobe and both column strobes high. With no row open, `close_gnt` is high at once. After a close, the next access takes the R6 path.
- R11: A column strobe is low only while `ras_n` is low. `we_n` is low only while `dq_oe` drives the bus. `we_n` and `oe_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request valid; taken on an edge where `ready` is high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 20 | Word address, row in bits 19:10, column in bits 9:0 |
| be | input | 2 | Byte enables, bit 1 upper byte, bit 0 lower byte |
| wdata | input | 16 | Write data |
| ready | output | 1 | Controller idle and able to take a request |
| rdata | output | 16 | Read data, disabled lanes zero |
| rvalid | output | 1 | One-cycle read completion pulse |
| wack | output | 1 | One-cycle write completion pulse |
| close_req | input | 1 | Ask for the open row to be precharged and the bus released |
| close_gnt | output | 1 | Row closed and bus released while `close_req` is high |
| mem_addr | output | 10 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| we_n | output | 1 | DRAM write enable, active low |
| oe_n | output | 1 | DRAM output enable, active low |
| dq_o | output | 16 | Data driven towards the DRAM |
| dq_oe | output | 1 | Drive enable for `dq_o` |
| dq_i | input | 16 | Data returned from the DRAM |

## Verification
Every result has a fixed due cycle, counted from the edge that accepts a request or first sees `close_req`:
- a page hit completes T_CAS edges later;
- an access with no row open completes T_RCD+T_CAS edges later;
- a row change completes T_RP+T_RCD+T_CAS edges later;
- `ready` returns T_CP edges after the completion pulse;
- `close_gnt` follows T_RP edges after `close_req` is first seen, or at once when no row is open.

The bench drives and samples on falling clock edges and counts the edges elapsed until each pulse appears. It compares that count to the sum the requirements give, and samples again one edge later to confirm the pulse has ended. A pin-level DRAM model in the bench captures row and column on the strobe falls. It stores and returns data per byte lane, fills disabled lanes with a non-zero pattern, and counts row openings, short precharges and strobe-ordering faults.

// File: rtl/dram_pkg.sv
`timescale 1ns/1ps
// Shared types for the page-mode DRAM controller.
// Assumes: one controller per DRAM device; states are only used inside the block.
package dram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // waiting; row may be left open
        ST_PRE,     // row strobe high before opening a new row
        ST_ROW,     // row strobe low, row address held, waiting for RAS-to-CAS
        ST_CAS,     // column strobes low for the access
        ST_CP,      // column strobes high between page cycles
        ST_CLOSE    // row strobe high on a close request
    } dstate_t;

endpackage

// File: rtl/dram_timer.sv
`timescale 1ns/1ps
// Down-counter that times every controller phase.
// Assumes: load carries (length - 1); done is high in the last cycle of the phase.
module dram_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    // Load a new phase length or count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/dram_row_track.sv
`timescale 1ns/1ps
// Open-row register with hit compare.
// Assumes: set and clear never arrive in the same cycle.
module dram_row_track #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set,
    input  logic             clr,
    input  logic [ROW_W-1:0] set_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             valid,
    output logic             hit
);

    logic [ROW_W-1:0] row_q;
    logic             valid_q;

    // Record the row being opened and mark it valid; drop validity on close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            valid_q <= 1'b0;
        end else if (set) begin
            row_q   <= set_row;
            valid_q <= 1'b1;
        end else if (clr) begin
            valid_q <= 1'b0;
        end
    end

    assign valid = valid_q;
    assign hit   = valid_q && (row_q == cmp_row);

    // R10: opening and closing are never requested together
    p_set_clr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(set && clr));

endmodule

// File: rtl/dram_rd_capture.sv
`timescale 1ns/1ps
// Captures read data per byte lane at the end of the strobe window and raises
// the completion pulses.
// Assumes: fire is high for exactly one cycle per access.
module dram_rd_capture #(
    parameter  int DATA_W = 16,
    localparam int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              is_wr,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              wack
);

    logic [7:0] lane_q [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Latch one byte lane on a read; disabled lanes are forced to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q[g] <= '0;
            else if (fire && !is_wr)
                lane_q[g] <= be[g] ? dq_i[g*8 +: 8] : 8'h00;
        end
        assign rdata[g*8 +: 8] = lane_q[g];
    end

    // One-cycle completion pulses, split by direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            wack   <= 1'b0;
        end else begin
            rvalid <= fire && !is_wr;
            wack   <= fire && is_wr;
        end
    end

    // R8: each completion pulse lasts a single cycle
    p_rvalid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);
    p_wack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wack |=> !wack);
    // R8: read data holds while no read is completing
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire && !is_wr) |=> $stable(rdata));

endmodule

// File: rtl/page_dram_ctrl.sv
`timescale 1ns/1ps
// Page-mode controller for an asynchronous DRAM with a shared row/column
// address bus and one column strobe per byte lane.
// Assumes: every timing parameter is at least 1 cycle; T_CAS covers the
// column access time at the clock period in use; the DRAM is only touched by
// this block unless close_gnt is high.
module page_dram_ctrl #(
    parameter  int ROW_W  = 10,
    parameter  int COL_W  = 10,
    parameter  int DATA_W = 16,
    parameter  int T_RP   = 3,
    parameter  int T_RCD  = 2,
    parameter  int T_CAS  = 4,
    parameter  int T_CP   = 1,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              wack,
    input  logic              close_req,
    output logic              close_gnt,
    output logic [MUX_W-1:0]  mem_addr,
    output logic              ras_n,
    output logic              ucas_n,
    output logic              lcas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_i
);
    import dram_pkg::*;

    localparam int T_MAX = (T_RP > T_RCD ? (T_RP > T_CAS ? (T_RP > T_CP ? T_RP : T_CP)
                                                         : (T_CAS > T_CP ? T_CAS : T_CP))
                                         : (T_RCD > T_CAS ? (T_RCD > T_CP ? T_RCD : T_CP)
                                                          : (T_CAS > T_CP ? T_CAS : T_CP)));
    localparam int TW = $clog2(T_MAX + 1);

    dstate_t           state_q, state_d;
    logic              t_load, t_done;
    logic [TW-1:0]     t_val;
    logic              row_set, row_clr, row_valid, row_hit;
    logic [ROW_W-1:0]  req_row, row_q, set_row;
    logic [COL_W-1:0]  col_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] wd_q;
    logic              wr_q, accept, fire;

    assign req_row = addr[ADDR_W-1:COL_W];
    assign accept  = (state_q == ST_IDLE) && req && !close_req;
    assign set_row = (state_q == ST_IDLE) ? req_row : row_q;
    assign fire    = (state_q == ST_CAS) && t_done;

    dram_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .val(t_val), .done(t_done)
    );

    dram_row_track #(.ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n), .set(row_set), .clr(row_clr),
        .set_row(set_row), .cmp_row(req_row), .valid(row_valid), .hit(row_hit)
    );

    dram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .fire(fire), .is_wr(wr_q), .be(be_q),
        .dq_i(dq_i), .rdata(rdata), .rvalid(rvalid), .wack(wack)
    );

    // Next-state, phase-length and row-tracking decisions.
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        row_set = 1'b0;
        row_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (close_req) begin
                    if (row_valid) begin
                        state_d = ST_CLOSE;
                        t_load  = 1'b1;
                        t_val   = TW'(T_RP - 1);
                    end
                end else if (req) begin
                    t_load = 1'b1;
                    if (row_hit) begin
                        state_d = ST_CAS;
                        t_val   = TW'(T_CAS - 1);
                    end else if (row_valid) begin
                        state_d = ST_PRE;
                        t_val   = TW'(T_RP - 1);
                    end else begin
                        state_d = ST_ROW;
                        t_val   = TW'(T_RCD - 1);
                        row_set = 1'b1;
                    end
                end
            end
            ST_PRE: if (t_done) begin
                state_d = ST_ROW;
                t_load  = 1'b1;
                t_val   = TW'(T_RCD - 1);
                row_set = 1'b1;
            end
            ST_ROW: if (t_done) begin
                state_d = ST_CAS;
                t_load  = 1'b1;
                t_val   = TW'(T_CAS - 1);
            end
            ST_CAS: if (t_done) begin
                state_d = ST_CP;
                t_load  = 1'b1;
                t_val   = TW'(T_CP - 1);
            end
            ST_CP: if (t_done) state_d = ST_IDLE;
            ST_CLOSE: if (t_done) begin
                state_d = ST_IDLE;
                row_clr = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Hold the accepted request for the duration of the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
            be_q  <= '0;
            wd_q  <= '0;
            wr_q  <= 1'b0;
        end else if (accept) begin
            row_q <= req_row;
            col_q <= addr[COL_W-1:0];
            be_q  <= be;
            wd_q  <= wdata;
            wr_q  <= we;
        end
    end

    // DRAM pin decode from the registered state.
    assign ras_n    = !(row_valid && state_q != ST_PRE && state_q != ST_CLOSE);
    assign mem_addr = (state_q == ST_ROW) ? MUX_W'(row_q) : MUX_W'(col_q);
    assign ucas_n   = !((state_q == ST_CAS) && be_q[LANES-1]);
    assign lcas_n   = !((state_q == ST_CAS) && be_q[0]);
    assign we_n     = !((state_q == ST_CAS) && wr_q);
    assign oe_n     = !((state_q == ST_CAS) && !wr_q);
    assign dq_oe    = (state_q == ST_CAS) && wr_q;
    assign dq_o     = wd_q;

    // Host handshake.
    assign ready     = (state_q == ST_IDLE) && !close_req;
    assign close_gnt = (state_q == ST_IDLE) && !row_valid && close_req;

    // Cycles the row strobe has been high, saturating; reset counts as precharged.
    logic [TW:0] ras_hi_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              ras_hi_q <= (TW+1)'(T_RP);
        else if (!ras_n)         ras_hi_q <= '0;
        else if (ras_hi_q < (TW+1)'(T_RP)) ras_hi_q <= ras_hi_q + 1'b1;
    end

    // R7: a row never opens before the precharge time has elapsed
    p_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (ras_hi_q >= (TW+1)'(T_RP)));
    // R11: column strobes only fall inside an open row
    p_cas_in_ras_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ucas_n && lcas_n) |-> !ras_n);
    // R9: an accepted request takes the controller out of idle
    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);
    // R10: the bus is released only with all strobes high
    p_gnt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        close_gnt |-> (ras_n && ucas_n && lcas_n));
    // R5: a page hit keeps the row strobe low into the column cycle
    p_hit_keeps_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && row_hit) |=> !ras_n);

endmodule

// File: tb/sim_page_dram_ctrl.sv
`timescale 1ns/1ps
// Directed bench for page_dram_ctrl with a pin-level DRAM model.
module sim_page_dram_ctrl;

    localparam int T_RP  = 3;
    localparam int T_RCD = 2;
    localparam int T_CAS = 4;
    localparam int T_CP  = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, close_req = 1'b0;
    logic [19:0] addr = '0;
    logic [1:0]  be = '0;
    logic [15:0] wdata = '0;
    logic        ready, rvalid, wack, close_gnt;
    logic [15:0] rdata, dq_o;
    logic [15:0] dq_i = 16'hA5A5;
    logic [9:0]  mem_addr;
    logic        ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    page_dram_ctrl #(.T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .be(be),
        .wdata(wdata), .ready(ready), .rdata(rdata), .rvalid(rvalid), .wack(wack),
        .close_req(close_req), .close_gnt(close_gnt), .mem_addr(mem_addr),
        .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .we_n(we_n), .oe_n(oe_n),
        .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
    );

    // ---------------- DRAM model, sampled on falling clock edges ----------------
    logic [15:0] mem [logic [19:0]];
    logic [9:0]  m_row = '0, m_col = '0;
    logic        p_ras = 1'b1, p_u = 1'b1, p_l = 1'b1;
    int          ras_falls = 0, short_pre = 0, proto_bad = 0, hi_cnt = 1000;

    function automatic logic [15:0] mrd(input logic [19:0] a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    always @(negedge clk) begin
        logic [15:0] w;
        if (p_ras && !ras_n) begin
            m_row = mem_addr;
            ras_falls++;
            if (hi_cnt < T_RP) short_pre++;
        end
        hi_cnt = ras_n ? hi_cnt + 1 : 0;
        if ((p_u && !ucas_n) || (p_l && !lcas_n)) begin
            m_col = mem_addr;
            if (!we_n) begin
                w = mrd({m_row, m_col});
                if (!ucas_n) w[15:8] = dq_o[15:8];
                if (!lcas_n) w[7:0]  = dq_o[7:0];
                mem[{m_row, m_col}] = w;
            end
        end
        if (!(ucas_n && lcas_n) && ras_n) proto_bad++;
        if (!we_n && !dq_oe) proto_bad++;
        if (!we_n && !oe_n) proto_bad++;
        if (!oe_n) begin
            w = mrd({m_row, m_col});
            dq_i = {!ucas_n ? w[15:8] : 8'hA5, !lcas_n ? w[7:0] : 8'hA5};
        end else begin
            dq_i = 16'hA5A5;
        end
        p_ras = ras_n; p_u = ucas_n; p_l = lcas_n;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Issue one access; n = falling edges until the completion pulse is seen
    // (accept edge counts as the first).
    task automatic xfer(input bit w, input logic [19:0] a, input logic [1:0] b,
                        input logic [15:0] d, output logic [15:0] rd, output int n);
        int g = 0;
        while (!ready && g < 1000) begin @(negedge clk); g++; end
        req = 1'b1; we = w; addr = a; be = b; wdata = d;
        @(negedge clk);
        req = 1'b0;
        n = 1;
        while (!(rvalid || wack) && n < 1000) begin @(negedge clk); n++; end
        if (n >= 1000) chk(1'b0, "WDOG", "access timeout", n, 0);
        rd = rdata;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        chk(ras_n && ucas_n && lcas_n, "R1", "strobes high", {ras_n, ucas_n, lcas_n}, 3'b111);
        chk(we_n && oe_n && !dq_oe, "R1", "we/oe/dq_oe idle", {we_n, oe_n, dq_oe}, 3'b110);
        chk(ready && !rvalid && !wack, "R1", "ready/rvalid/wack", {ready, rvalid, wack}, 3'b100);
    endtask

    task automatic t_first_write;
        logic [15:0] rd; int n; int f0 = ras_falls;
        xfer(1'b1, 20'h12345, 2'b11, 16'hBEEF, rd, n);
        chk(n == T_RCD + T_CAS + 1, "R6", "closed-row latency", n - 1, T_RCD + T_CAS);
        chk(ras_falls == f0 + 1, "R6", "row openings", ras_falls - f0, 1);
        chk(m_row == 10'h048, "R2", "row on bus", m_row, 10'h048);
        chk(m_col == 10'h345, "R2", "column on bus", m_col, 10'h345);
        chk(wack && !rvalid, "R8", "write pulse kind", {wack, rvalid}, 2'b10);
        @(negedge clk);
        chk(!wack, "R8", "wack one cycle", wack, 0);
    endtask

    task automatic t_hit_read;
        logic [15:0] rd; int n; int c; int f0 = ras_falls;
        xfer(1'b0, 20'h12345, 2'b11, 16'h0, rd, n);
        chk(n == T_CAS + 1, "R5", "page-hit latency", n - 1, T_CAS);
        chk(ras_falls == f0, "R5", "no row reopen", ras_falls - f0, 0);
        chk(rd == 16'hBEEF, "R3", "read back", rd, 16'hBEEF);
        chk(!ready, "R9", "busy at completion", ready, 0);
        @(negedge clk);
        c = 1;
        chk(!rvalid, "R8", "rvalid one cycle", rvalid, 0);
        chk(rdata == 16'hBEEF, "R8", "rdata held", rdata, 16'hBEEF);
        while (!ready && c < 100) begin @(negedge clk); c++; end
        chk(c == T_CP, "R9", "ready return", c, T_CP);
    endtask

    task automatic t_bytes;
        logic [15:0] rd; int n;
        xfer(1'b1, 20'h12346, 2'b11, 16'h1234, rd, n);
        xfer(1'b1, 20'h12346, 2'b10, 16'hCDEF, rd, n);
        xfer(1'b0, 20'h12346, 2'b11, 16'h0, rd, n);
        chk(rd == 16'hCD34, "R4", "upper-only write", rd, 16'hCD34);
        xfer(1'b0, 20'h12346, 2'b01, 16'h0, rd, n);
        chk(rd == 16'h0034, "R4", "lower-lane read", rd, 16'h0034);
        xfer(1'b0, 20'h12346, 2'b10, 16'h0, rd, n);
        chk(rd == 16'hCD00, "R4", "upper-lane read", rd, 16'hCD00);
        xfer(1'b1, 20'h12346, 2'b01, 16'h9977, rd, n);
        xfer(1'b0, 20'h12346, 2'b11, 16'h0, rd, n);
        chk(rd == 16'hCD77, "R4", "lower-only write", rd, 16'hCD77);
    endtask

    task automatic t_miss_open;
        logic [15:0] rd; int n; int f0 = ras_falls;
        xfer(1'b1, 20'hFFC00, 2'b11, 16'h5A5A, rd, n);
        chk(n == T_RP + T_RCD + T_CAS + 1, "R7", "row-change latency", n - 1, T_RP + T_RCD + T_CAS);
        chk(ras_falls == f0 + 1, "R7", "one reopen", ras_falls - f0, 1);
        chk(m_row == 10'h3FF && m_col == 10'h000, "R2", "far row/col", {m_row, m_col}, 20'hFFC00);
        xfer(1'b0, 20'h12345, 2'b11, 16'h0, rd, n);
        chk(rd == 16'hBEEF, "R3", "data after row change", rd, 16'hBEEF);
        chk(short_pre == 0, "R7", "precharge violations", short_pre, 0);
    endtask

    task automatic t_close;
        logic [15:0] rd; int n; int f0;
        @(negedge clk);
        close_req = 1'b1;
        #0;
        chk(!ready, "R10", "ready low during close", ready, 0);
        n = 0;
        while (!close_gnt && n < 100) begin @(negedge clk); n++; end
        chk(n == T_RP + 1, "R10", "grant delay", n - 1, T_RP);
        chk(ras_n && ucas_n && lcas_n, "R10", "strobes at grant", {ras_n, ucas_n, lcas_n}, 3'b111);
        close_req = 1'b0;
        @(negedge clk);
        f0 = ras_falls;
        close_req = 1'b1;
        #0;
        chk(close_gnt, "R10", "grant with no open row", close_gnt, 1);
        @(negedge clk);
        close_req = 1'b0;
        chk(ras_falls == f0, "R10", "no row activity", ras_falls - f0, 0);
        xfer(1'b0, 20'hFFC00, 2'b11, 16'h0, rd, n);
        chk(n == T_RCD + T_CAS + 1, "R10", "access after close", n - 1, T_RCD + T_CAS);
        chk(rd == 16'h5A5A, "R3", "data after close", rd, 16'h5A5A);
    endtask

    task automatic t_sweep;
        logic [15:0] rd; int n; int f0; int bad = 0;
        xfer(1'b0, {10'h155, 10'h000}, 2'b11, 16'h0, rd, n);
        f0 = ras_falls;
        for (int i = 0; i < 8; i++)
            xfer(1'b1, {10'h155, 10'(i * 37)}, 2'b11, 16'(16'h3C00 ^ (i * 16'h1111)), rd, n);
        for (int i = 0; i < 8; i++) begin
            xfer(1'b0, {10'h155, 10'(i * 37)}, 2'b11, 16'h0, rd, n);
            if (rd != 16'(16'h3C00 ^ (i * 16'h1111))) bad++;
        end
        chk(ras_falls == f0, "R5", "page sweep row opens", ras_falls - f0, 0);
        chk(bad == 0, "R3", "page sweep mismatches", bad, 0);
        f0 = ras_falls;
        for (int i = 0; i < 4; i++)
            xfer(1'b0, (i % 2 == 0) ? 20'h12345 : 20'hFFC00, 2'b11, 16'h0, rd, n);
        chk(ras_falls == f0 + 4, "R7", "alternating rows", ras_falls - f0, 4);
        chk(rd == 16'h5A5A, "R3", "alternating data", rd, 16'h5A5A);
        chk(proto_bad == 0, "R11", "strobe ordering faults", proto_bad, 0);
        chk(short_pre == 0, "R7", "precharge violations", short_pre, 0);
    endtask

    // ---------------- main ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_write();
        t_hit_read();
        t_bytes();
        t_miss_open();
        t_close();
        t_sweep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL WDOG run did not finish: actual %0d expected %0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule